// File: doc/BRIEF.md
# Tile-Chained Configuration Loader

This block fills the memory-based configuration storage of an array of tiles from one serial stream of configuration words. All tiles share a single write-address bus and a single data bus. Each lane of the data word feeds a different memory inside a tile. A write-enable token, held in a chain of flops with one flop per tile, decides which tile takes the words. Only the tile that holds the token is written.

A begin pulse puts the token on tile 0 and clears the shared address counter. Each accepted stream word is written at the current address, and then the counter steps. When the counter wraps past its last address, the overflow is captured in a flop. For that one cycle the stream is held off, and the token moves on to the next tile. When the token leaves the last tile, the load is finished and a done flag rises. The flag stays high until the next begin pulse.

The word input is a valid/ready stream. A word is accepted in a cycle where `s_valid` and `s_ready` are both high, and only then. `s_ready` is low in three cases: while idle or done, and in the single wrap cycle after each tile's final word. A source may hold `s_valid` low for any number of cycles. The address and token then hold their values, and nothing is written. While ready is low, the source must keep its word steady until it is taken.

Top module: `cfgld_loader`

## Requirements
- R1: After reset, `cfg_we` is all zero, `s_ready` and `done_o` are low, and `cfg_addr` is 0.
- R2: A begin pulse taken while no load is active places the token on tile 0 and clears the counter. In the following cycle, `s_ready` is high, `done_o` is low and `cfg_addr` is 0.
- R3: `cfg_we` is one-hot or zero. A bit of `cfg_we` is high only in a cycle that accepts a word. `cfg_we[t]` is high only for the tile t that holds the token. `cfg_data` carries the accepted word on all lanes.
- R4: `cfg_addr` changes only when a word is accepted, and then it increments by one, wrapping from 2^ADDR_W-1 to 0. Tile t therefore receives word number t*2^ADDR_W + a at address a.
- R5: The cycle after a tile's last address is written, `s_ready` is low. After that cycle, the token sits on the next tile. With `s_valid` held high, a full load shows exactly NUM_TILES-1 stall cycles before its last word.
- R6: After the last tile's final word, there is one cycle with `s_ready` low and `done_o` still low. Then `done_o` rises and stays high, with `s_ready` low, until a begin pulse.
- R7: A begin pulse while a load is active has no effect, including a pulse that falls in the final wrap cycle.
- R8: A begin pulse while `done_o` is high drops `done_o` in the next cycle and starts a new load at tile 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| begin_i | input | 1 | Pulse that starts a load |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Loader can take a word this cycle |
| s_data | input | LANES | Stream word, one bit per tile memory |
| cfg_addr | output | ADDR_W | Shared write address for all tile memories |
| cfg_data | output | LANES | Broadcast write data |
| cfg_we | output | NUM_TILES | Per-tile write enable |
| done_o | output | 1 | Load complete, held until next begin |

## Verification
A begin pulse can land in the same cycle as the final token shift, which is the wrap cycle after the last word. The bench provokes this by raising `begin_i` in exactly that cycle, and in every other stall cycle of a load. It judges the result by whether `done_o` rises and then stays high with `s_ready` low. A begin that was wrongly taken would instead show ready high and done low. A second overlap, a begin pulse together with an accepted word, is made at random points of a load. It is judged by reading back every tile memory, including the order in which the words were written.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_RUN  = 2'd1,
    LD_DONE = 2'd2
  } ld_state_e;
endpackage

// File: rtl/cfgld_addr_counter.sv
module cfgld_addr_counter #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap_q
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      if (inc) cnt_q <= cnt_q + 1'b1;
      wrap_q <= inc && (cnt_q == LAST);
    end
  end

  assign addr = cnt_q;
endmodule

// File: rtl/cfgld_token_chain.sv
module cfgld_token_chain #(
  parameter int NUM_TILES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 shift,
  output logic [NUM_TILES-1:0] tok,
  output logic                 last_o
);
  logic [NUM_TILES-1:0] tok_q;

  for (genvar i = 0; i < NUM_TILES; i++) begin : g_stage
    logic nxt;
    if (i == 0) begin : g_head
      always_comb begin
        if (load)       nxt = 1'b1;
        else if (shift) nxt = 1'b0;
        else            nxt = tok_q[0];
      end
    end else begin : g_body
      always_comb begin
        if (load)       nxt = 1'b0;
        else if (shift) nxt = tok_q[i-1];
        else            nxt = tok_q[i];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tok_q[i] <= 1'b0;
      else        tok_q[i] <= nxt;
    end
  end

  assign tok    = tok_q;
  assign last_o = tok_q[NUM_TILES-1];
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic begin_i,
  input  logic wrap_q,
  input  logic tok_last,
  output logic start,
  output logic ready,
  output logic done
);
  ld_state_e st_q, st_d;
  logic      finish;

  assign start  = begin_i && (st_q != LD_RUN);
  assign finish = (st_q == LD_RUN) && wrap_q && tok_last;

  always_comb begin
    st_d = st_q;
    if (start)       st_d = LD_RUN;
    else if (finish) st_d = LD_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LD_IDLE;
    else        st_q <= st_d;
  end

  assign ready = (st_q == LD_RUN) && !wrap_q;
  assign done  = (st_q == LD_DONE);
endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader #(
  parameter int NUM_TILES = 4,
  parameter int ADDR_W    = 3,
  parameter int LANES     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 begin_i,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [LANES-1:0]     s_data,
  output logic [ADDR_W-1:0]    cfg_addr,
  output logic [LANES-1:0]     cfg_data,
  output logic [NUM_TILES-1:0] cfg_we,
  output logic                 done_o
);
  logic                 start, ready, accept, wrap_q, tok_last;
  logic [NUM_TILES-1:0] tok;

  assign accept = s_valid && ready;

  cfgld_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .begin_i (begin_i),
    .wrap_q  (wrap_q),
    .tok_last(tok_last),
    .start   (start),
    .ready   (ready),
    .done    (done_o)
  );

  cfgld_addr_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .inc   (accept),
    .addr  (cfg_addr),
    .wrap_q(wrap_q)
  );

  cfgld_token_chain #(.NUM_TILES(NUM_TILES)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .shift (wrap_q),
    .tok   (tok),
    .last_o(tok_last)
  );

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_we
    assign cfg_we[t] = tok[t] && accept;
  end

  assign cfg_data = s_data;
  assign s_ready  = ready;
endmodule

// File: rtl/cfgld_loader_chk.sv
module cfgld_loader_chk #(
  parameter int NUM_TILES = 4,
  parameter int ADDR_W    = 3,
  parameter int LANES     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 begin_i,
  input logic                 s_valid,
  input logic                 s_ready,
  input logic [LANES-1:0]     s_data,
  input logic [ADDR_W-1:0]    cfg_addr,
  input logic [LANES-1:0]     cfg_data,
  input logic [NUM_TILES-1:0] cfg_we,
  input logic                 done_o
);
  assert_we_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_we));

  assert_we_needs_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_we) |-> (s_valid && s_ready));

  assert_data_broadcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_we) |-> (cfg_data == s_data));

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> $stable(cfg_addr));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (cfg_addr == $past(cfg_addr) + 1'b1));

  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !begin_i) |=> done_o);

  assert_done_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !s_ready);

  assert_begin_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && begin_i && !s_valid) |=> (s_ready && $stable(cfg_addr)));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && begin_i) |=> (!done_o && s_ready && cfg_addr == '0));
endmodule

bind cfgld_loader cfgld_loader_chk #(
  .NUM_TILES(NUM_TILES), .ADDR_W(ADDR_W), .LANES(LANES)
) u_chk (.*);

// File: tb/cfgld_loader_bench.sv
module cfgld_loader_bench;
  localparam int NT    = 4;
  localparam int AW    = 3;
  localparam int LN    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int TOTAL = NT * DEPTH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          begin_i = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [LN-1:0] s_data = '0;
  logic [AW-1:0] cfg_addr;
  logic [LN-1:0] cfg_data;
  logic [NT-1:0] cfg_we;
  logic          done_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [LN-1:0] mem [NT][DEPTH];
  int            ord [NT][DEPTH];
  int            wcount = 0;
  logic [LN-1:0] exp_data [TOTAL];

  always #10 clk = ~clk;

  cfgld_loader #(.NUM_TILES(NT), .ADDR_W(AW), .LANES(LN)) u_cfgld_loader (
    .clk(clk), .rst_n(rst_n), .begin_i(begin_i), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_we(cfg_we), .done_o(done_o)
  );

  // tile memory models
  always @(posedge clk) begin
    for (int t = 0; t < NT; t++) begin
      if (cfg_we[t]) begin
        mem[t][cfg_addr] <= cfg_data;
        ord[t][cfg_addr] <= wcount;
      end
    end
    if (|cfg_we) wcount <= wcount + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic start_load();
    @(negedge clk) begin_i = 1'b1;
    @(negedge clk) begin_i = 1'b0;
    check(s_ready == 1'b1, "R2 ready", int'(s_ready), 1);
    check(done_o == 1'b0, "R2/R8 done low", int'(done_o), 0);
    check(cfg_addr == '0, "R2 addr", int'(cfg_addr), 0);
  endtask

  task automatic fill_data();
    for (int i = 0; i < TOTAL; i++) exp_data[i] = LN'($urandom);
  endtask

  task automatic send_all(input bit gaps, input bit pulse_begin, output int stalls);
    int sent = 0;
    stalls = 0;
    while (sent < TOTAL) begin
      @(negedge clk);
      if (gaps && ($urandom % 3 == 0)) begin
        s_valid = 1'b0;
        begin_i = pulse_begin;
        #1;
        check(cfg_we == '0, "R3 no write without valid", int'(cfg_we), 0);
      end else begin
        s_valid = 1'b1;
        s_data  = exp_data[sent];
        begin_i = pulse_begin && ($urandom % 4 == 0);
        #1;
        if (s_ready) sent++;
        else begin
          stalls++;
          begin_i = pulse_begin;
        end
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    begin_i = pulse_begin;  // lands in the final wrap cycle
    check(s_ready == 1'b0, "R6 wrap ready low", int'(s_ready), 0);
    check(done_o == 1'b0, "R6 done not yet", int'(done_o), 0);
    @(negedge clk);
    begin_i = 1'b0;
    check(done_o == 1'b1, "R6 done rises", int'(done_o), 1);
    check(s_ready == 1'b0, "R6/R7 ready low after done", int'(s_ready), 0);
    check(cfg_addr == '0, "R4 addr wrapped", int'(cfg_addr), 0);
  endtask

  task automatic verify_mem(input int base);
    for (int t = 0; t < NT; t++) begin
      for (int a = 0; a < DEPTH; a++) begin
        int idx = t * DEPTH + a;
        check(mem[t][a] == exp_data[idx], "R3 tile content",
              int'(mem[t][a]), int'(exp_data[idx]));
        check(ord[t][a] == base + idx, "R4 write order", ord[t][a], base + idx);
      end
    end
    check(wcount == base + TOTAL, "R3 write count", wcount, base + TOTAL);
  endtask

  initial begin
    int stalls;
    int base;
    repeat (3) @(negedge clk);
    check(cfg_we == '0, "R1 we", int'(cfg_we), 0);
    check(s_ready == 1'b0, "R1 ready", int'(s_ready), 0);
    check(done_o == 1'b0, "R1 done", int'(done_o), 0);
    check(cfg_addr == '0, "R1 addr", int'(cfg_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ready == 1'b0, "R1 idle after reset", int'(s_ready), 0);

    // load 1: continuous stream
    fill_data();
    base = wcount;
    start_load();
    send_all(1'b0, 1'b0, stalls);
    check(stalls == NT - 1, "R5 stall cycles", stalls, NT - 1);
    verify_mem(base);
    repeat (5) @(negedge clk);
    check(done_o == 1'b1, "R6 done held", int'(done_o), 1);
    check(wcount == base + TOTAL, "R6 no writes when done", wcount, base + TOTAL);

    // load 2: restart from done, gaps, begin pulses inside the load
    fill_data();
    base = wcount;
    start_load();
    send_all(1'b1, 1'b1, stalls);
    verify_mem(base);
    repeat (3) @(negedge clk);
    check(done_o == 1'b1, "R7 begin in final wrap ignored", int'(done_o), 1);

    // load 3: continuous stream with begin pulses at every stall
    fill_data();
    base = wcount;
    start_load();
    send_all(1'b0, 1'b1, stalls);
    check(stalls == NT - 1, "R5/R7 stall cycles with begin", stalls, NT - 1);
    verify_mem(base);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule